// File: doc/BRIEF.md
# Serial Converter Output Emulator

This block stands in for the serial side of a 12-bit or 10-bit sampling converter. It lets a readout controller be looped back on itself in self-checking tests. The controller drives an active-low chip select and a serial clock. The block watches both pins through synchronizers running on a faster system clock.

When chip select falls, the block captures the parallel sample word and the width mode. It builds a 16-bit frame from them and starts driving that frame one bit at a time. The first bit appears at once. Each later bit follows a falling serial clock edge.

The data pin is modelled as a value plus an output-enable bit, so the chip needs no internal tri-state nets. A hold/track status output marks the window in which the emulated converter holds its input.

Top module: `serout_emu`

## Requirements
- R1: After reset, `sdo_oe_o` is 0, `hold_o` is 0 (track) and `sdo_o` is 0.
- R2: Within three system clocks of a chip select fall, `sdo_oe_o` is 1, `hold_o` is 1 and `sdo_o` carries frame bit 15, which is a leading 0.
- R3: With `mode_10b_i` at 0, the frame is `{4'b0000, sample_i[11:0]}`. Bit 15 goes first, and after the k-th serial clock fall `sdo_o` shows frame bit 15-k.
- R4: With `mode_10b_i` at 1, the frame is `{4'b0000, sample_i[9:0], 2'b00}`, shifted out in the same order as in R3.
- R5: Sample word and mode are captured at the chip select fall. Changes to them during a frame do not alter the bits being shifted out.
- R6: `hold_o` stays 1 through the 13th serial clock fall. It drops to 0 on the serial clock rise that follows the 13th fall.
- R7: On the 16th serial clock fall of a frame, `sdo_oe_o` returns to 0.
- R8: Further serial clock edges after the 16th fall, with chip select still low, keep `sdo_oe_o` at 0 and do not restart the frame.
- R9: A chip select rise before the 16th fall sets `sdo_oe_o` and `hold_o` to 0 at once and abandons the frame. The next chip select fall starts a fresh frame.
- R10: If a serial clock fall is seen in the same synchronized cycle as the chip select fall, that clock fall is not counted. The frame still starts with bit 15, and 16 further falls are needed to end it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select pin, active low, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sample_i | input | 12 | Parallel sample word |
| mode_10b_i | input | 1 | 1 selects the 10-bit frame layout |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Output enable for the data pin; 0 means high impedance |
| hold_o | output | 1 | 1 while holding, 0 while tracking |

## Verification
Two events can land in the same synchronized cycle: the start of a frame on a chip select fall, and the counting of a serial clock fall. The bench provokes this by dropping chip select and the serial clock at the same instant, so both edges pass through the synchronizers together. It then judges the outcome at the pins. The first bit must still be the leading zero, every later bit must follow a further fall, and the output enable must stay high until the 16th further fall.

// File: rtl/serout_pkg.sv
package serout_pkg;

   // Edge events recovered from the synchronized pins, valid for one clk cycle
   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic sclk_fall;
      logic sclk_rise;
   } serout_evt_t;

   // Index of each pin inside the synchronizer vector
   localparam int unsigned PIN_CS   = 0;
   localparam int unsigned PIN_SCLK = 1;
   localparam int unsigned PIN_NUM  = 2;

endpackage

// File: rtl/serout_sync.sv
module serout_sync #(
   parameter int unsigned             WIDTH   = 2,
   parameter int unsigned             STAGES  = 2,
   parameter logic [WIDTH-1:0]        RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] level_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   logic [WIDTH-1:0] stage_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign level_o = stage_q[STAGES-1];
   assign rise_o  = stage_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/serout_frame.sv
module serout_frame #(
   parameter int unsigned LEAD_W    = 4,
   parameter int unsigned SAMPLE_W  = 12,
   parameter int unsigned NARROW_W  = 10,
   parameter bit          NARROW_EN = 1'b1,
   localparam int unsigned FRAME_W  = LEAD_W + SAMPLE_W
) (
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                narrow_i,
   output logic [FRAME_W-1:0]  frame_o
);

   localparam int unsigned PAD_W = SAMPLE_W - NARROW_W;

   logic [FRAME_W-1:0] wide_frame;

   // Leading zeros come from zero extension; sample MSB lands on bit SAMPLE_W-1
   assign wide_frame = FRAME_W'(sample_i);

   generate
      if (NARROW_EN) begin : g_narrow
         logic [FRAME_W-1:0] narrow_frame;
         // Narrow sample sits just below the leading zeros, trailing pad below it
         assign narrow_frame = FRAME_W'(sample_i[NARROW_W-1:0]) << PAD_W;
         assign frame_o      = narrow_i ? narrow_frame : wide_frame;
      end else begin : g_wide_only
         logic unused_mode;
         assign unused_mode = narrow_i;
         assign frame_o     = wide_frame;
      end
   endgenerate

endmodule

// File: rtl/serout_ctrl.sv
module serout_ctrl
   import serout_pkg::*;
#(
   parameter int unsigned FRAME_W     = 16,
   parameter int unsigned TRACK_AFTER = 13,
   parameter int unsigned CNT_W       = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  serout_evt_t        ev_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               sdo_o,
   output logic               oe_o,
   output logic               hold_o,
   output logic [CNT_W-1:0]   fall_cnt_o
);

   localparam logic [CNT_W-1:0] LAST_FALL  = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] TRACK_FALL = CNT_W'(TRACK_AFTER);

   logic [FRAME_W-1:0] shreg_q;
   logic               oe_q;
   logic               hold_q;
   logic               arm_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   cnt_nx;

   assign cnt_nx = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         oe_q    <= 1'b0;
         hold_q  <= 1'b0;
         arm_q   <= 1'b0;
         cnt_q   <= '0;
      end else if (ev_i.cs_rise) begin
         // Frame abandoned or finished: release pin and go back to track
         oe_q   <= 1'b0;
         hold_q <= 1'b0;
         arm_q  <= 1'b0;
      end else if (ev_i.cs_fall) begin
         // Frame start outranks any serial clock edge seen in the same cycle
         shreg_q <= frame_i;
         oe_q    <= 1'b1;
         hold_q  <= 1'b1;
         arm_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (oe_q && ev_i.sclk_fall) begin
            cnt_q   <= cnt_nx;
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            if (cnt_nx == LAST_FALL)  oe_q  <= 1'b0;
            if (cnt_nx == TRACK_FALL) arm_q <= 1'b1;
         end
         if (arm_q && ev_i.sclk_rise) begin
            hold_q <= 1'b0;
            arm_q  <= 1'b0;
         end
      end
   end

   assign sdo_o      = oe_q & shreg_q[FRAME_W-1];
   assign oe_o       = oe_q;
   assign hold_o     = hold_q;
   assign fall_cnt_o = cnt_q;

endmodule

// File: rtl/serout_emu.sv
module serout_emu
   import serout_pkg::*;
#(
   parameter int unsigned LEAD_W      = 4,
   parameter int unsigned SAMPLE_W    = 12,
   parameter int unsigned NARROW_W    = 10,
   parameter bit          NARROW_EN   = 1'b1,
   parameter int unsigned TRACK_AFTER = 13,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n_i,
   input  logic                sclk_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                mode_10b_i,
   output logic                sdo_o,
   output logic                sdo_oe_o,
   output logic                hold_o
);

   localparam int unsigned FRAME_LEN = LEAD_W + SAMPLE_W;
   localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("serout_emu: SYNC_STAGES must be at least 2");
   end
   if (NARROW_W == 0 || NARROW_W > SAMPLE_W) begin : g_chk_narrow
      $error("serout_emu: NARROW_W must be in 1..SAMPLE_W");
   end
   if (TRACK_AFTER == 0 || TRACK_AFTER >= FRAME_LEN) begin : g_chk_track
      $error("serout_emu: TRACK_AFTER must be in 1..FRAME_LEN-1");
   end

   logic [PIN_NUM-1:0] pins;
   logic [PIN_NUM-1:0] pin_lvl;
   logic [PIN_NUM-1:0] pin_rise;
   logic [PIN_NUM-1:0] pin_fall;
   serout_evt_t        ev;
   logic [FRAME_LEN-1:0] frame;
   logic [CNT_W-1:0]   fall_cnt;
   logic               unused_lvl;

   assign pins[PIN_CS]   = cs_n_i;
   assign pins[PIN_SCLK] = sclk_i;

   serout_sync #(
      .WIDTH   (PIN_NUM),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({PIN_NUM{1'b1}})
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pins),
      .level_o (pin_lvl),
      .rise_o  (pin_rise),
      .fall_o  (pin_fall)
   );

   assign unused_lvl   = ^pin_lvl;
   assign ev.cs_fall   = pin_fall[PIN_CS];
   assign ev.cs_rise   = pin_rise[PIN_CS];
   assign ev.sclk_fall = pin_fall[PIN_SCLK];
   assign ev.sclk_rise = pin_rise[PIN_SCLK];

   serout_frame #(
      .LEAD_W    (LEAD_W),
      .SAMPLE_W  (SAMPLE_W),
      .NARROW_W  (NARROW_W),
      .NARROW_EN (NARROW_EN)
   ) u_frame (
      .sample_i (sample_i),
      .narrow_i (mode_10b_i),
      .frame_o  (frame)
   );

   serout_ctrl #(
      .FRAME_W     (FRAME_LEN),
      .TRACK_AFTER (TRACK_AFTER),
      .CNT_W       (CNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_i       (ev),
      .frame_i    (frame),
      .sdo_o      (sdo_o),
      .oe_o       (sdo_oe_o),
      .hold_o     (hold_o),
      .fall_cnt_o (fall_cnt)
   );

endmodule

// File: rtl/serout_emu_chk.sv
module serout_emu_chk
   import serout_pkg::*;
#(
   parameter int unsigned FRAME_LEN   = 16,
   parameter int unsigned TRACK_AFTER = 13,
   parameter int unsigned CNT_W       = 5
) (
   input logic             clk,
   input logic             rst_n,
   input serout_evt_t      ev,
   input logic [CNT_W-1:0] fall_cnt,
   input logic             sdo_o,
   input logic             sdo_oe_o,
   input logic             hold_o
);

   // R1: leaving reset the pin is released and the model tracks
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!sdo_oe_o && !hold_o));

   // R2: a chip select fall drives the leading zero and enters hold
   a_r2_start_drive: assert property (@(posedge clk) disable iff (!rst_n)
      ev.cs_fall |=> (sdo_oe_o && hold_o && !sdo_o));

   // R6: hold persists until the track point has been reached
   a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_o && (int'(fall_cnt) < TRACK_AFTER) && !ev.cs_rise) |=> hold_o);

   // R7: the last counted fall releases the pin
   a_r7_last_fall_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe_o && ev.sclk_fall && !ev.cs_fall && !ev.cs_rise
       && (int'(fall_cnt) == FRAME_LEN - 1)) |=> !sdo_oe_o);

   // R8: once released, only a new chip select fall re-enables the pin
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (!sdo_oe_o && !ev.cs_fall) |=> !sdo_oe_o);

   // R9: a chip select rise ends everything at once
   a_r9_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      ev.cs_rise |=> (!sdo_oe_o && !hold_o));

   // R10: a coincident clock fall does not advance the new frame
   a_r10_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.cs_fall && ev.sclk_fall) |=> (fall_cnt == '0));

endmodule

bind serout_emu serout_emu_chk #(
   .FRAME_LEN   (FRAME_LEN),
   .TRACK_AFTER (TRACK_AFTER),
   .CNT_W       (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ev       (ev),
   .fall_cnt (fall_cnt),
   .sdo_o    (sdo_o),
   .sdo_oe_o (sdo_oe_o),
   .hold_o   (hold_o)
);

// File: tb/serout_emu_tb.sv
`timescale 1ns/1ps
module serout_emu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic [11:0] sample = '0;
   logic        mode10 = 1'b0;
   logic        sdo, sdo_oe, hold;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   serout_emu u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_i     (cs_n),
      .sclk_i     (sclk),
      .sample_i   (sample),
      .mode_10b_i (mode10),
      .sdo_o      (sdo),
      .sdo_oe_o   (sdo_oe),
      .hold_o     (hold)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Wait out the synchronizer and register latency, then sample mid-cycle
   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 oe", 32'(sdo_oe), 0);
      chk("R1 hold", 32'(hold), 0);
      chk("R1 sdo", 32'(sdo), 0);
   endtask

   // One frame: start, 15 bit falls, 16th fall, optional extra edges, deselect
   task automatic t_frame(input logic [11:0] smp, input logic m10,
                          input logic [11:0] smp_late, input bit coincide,
                          input int extra);
      logic [15:0] exp;
      string dreq;
      exp  = m10 ? {4'b0, smp[9:0], 2'b0} : {4'b0, smp};
      dreq = coincide ? "R10 data" : (smp_late !== smp) ? "R5 data"
             : m10 ? "R4 data" : "R3 data";
      sample = smp;
      mode10 = m10;
      cs_n   = 1'b0;
      if (coincide) sclk = 1'b0;
      settle();
      chk("R2 oe", 32'(sdo_oe), 1);
      chk("R2 hold", 32'(hold), 1);
      chk("R2 first bit", 32'(sdo), 32'(exp[15]));
      sample = smp_late;
      mode10 = ~m10;
      if (coincide) begin
         sclk = 1'b1;
         settle();
         chk("R10 bit15 kept", 32'(sdo), 32'(exp[15]));
      end
      for (int i = 1; i < 16; i++) begin
         sclk = 1'b0;
         settle();
         chk(dreq, 32'(sdo), 32'(exp[15-i]));
         chk("R7 oe mid", 32'(sdo_oe), 1);
         if (i == 13) chk("R6 hold at 13", 32'(hold), 1);
         sclk = 1'b1;
         settle();
         if (i == 13) chk("R6 track after rise", 32'(hold), 0);
      end
      sclk = 1'b0;
      settle();
      chk("R7 hiz at 16", 32'(sdo_oe), 0);
      sclk = 1'b1;
      settle();
      for (int j = 0; j < extra; j++) begin
         sclk = 1'b0;
         settle();
         chk("R8 oe after extra fall", 32'(sdo_oe), 0);
         chk("R8 hold", 32'(hold), 0);
         sclk = 1'b1;
         settle();
      end
      cs_n = 1'b1;
      settle();
      mode10 = m10;
   endtask

   task automatic t_early(input int falls);
      sample = 12'hFFF;
      mode10 = 1'b0;
      cs_n   = 1'b0;
      settle();
      for (int i = 0; i < falls; i++) begin
         sclk = 1'b0; settle();
         sclk = 1'b1; settle();
      end
      chk("R9 oe before abort", 32'(sdo_oe), 1);
      chk("R9 sdo before abort", 32'(sdo), 32'(falls >= 4));
      cs_n = 1'b1;
      settle();
      chk("R9 oe after abort", 32'(sdo_oe), 0);
      chk("R9 hold after abort", 32'(hold), 0);
      sclk = 1'b0; settle();
      chk("R9 no drive while deselected", 32'(sdo_oe), 0);
      sclk = 1'b1; settle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_frame(12'hA5C, 1'b0, 12'hA5C, 1'b0, 0);
      t_frame(12'h3FF, 1'b1, 12'h3FF, 1'b0, 0);
      t_frame(12'h2B7, 1'b1, 12'h2B7, 1'b0, 0);
      t_frame(12'h813, 1'b0, 12'h7EC, 1'b0, 0);
      t_frame(12'hFFF, 1'b0, 12'hFFF, 1'b0, 3);
      t_early(6);
      t_frame(12'h5A5, 1'b0, 12'h5A5, 1'b0, 0);
      t_frame(12'hC39, 1'b0, 12'hC39, 1'b1, 0);
      t_frame(12'h1AB, 1'b1, 12'h1AB, 1'b1, 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule